// File: doc/BRIEF.md
# Trace Resynchronization Trigger Unit

This block sits beside an instruction trace encoder and decides, for every instruction that retires while tracing is on, whether that instruction must be sent as a full synchronization point instead of a compressed delta. When a sync is needed it also gives a two-bit code saying why. It raises a sync for four causes: the first traced instruction after reset, the first traced instruction after tracing is switched on, the first handler instruction after a trap, and a periodic timeout that bounds how long the decoder can run without a sync.

The unit also flags the instruction that retires together with a trap or halt indication, so the encoder reports where normal program flow stopped. It holds a small run-time configuration word. When a write changes that word, the unit raises a one-cycle request for a configuration-report packet. When bit 0 of the word is set, the unit forces full addresses on every traced instruction. The outputs are combinational from the current retire strobe and registered state, so the encoder sees its decision in the same cycle as the retire.

Top module: `trace_resync_unit`

## Requirements
- R1: The first traced retire (iret_valid_i and trace_en_i both high) after reset raises sync_req_o with sync_reason_o = 0.
- R2: The first traced retire at or after a rising edge of trace_en_i raises sync_req_o with sync_reason_o = 1, unless a higher-priority cause is pending.
- R3: A trap_i pulse makes the first traced retire in a later cycle a sync with sync_reason_o = 2, unless a higher-priority cause is pending. A retire in the same cycle as trap_i is not the handler entry.
- R4: A counter of traced retires without a sync forces a sync with sync_reason_o = 3 on the traced retire found with the counter at 2^CNT_W-1. The counter never wraps.
- R5: The counter returns to zero on every sync, whatever its reason, so a timeout never follows a sync by fewer than 2^CNT_W traced retires.
- R6: When several causes hold at once, the reason follows the priority reset (0), then trace start (1), then trap (2), then timeout (3).
- R7: last_o is high exactly on a traced retire that comes in the same cycle as trap_i or halt_i.
- R8: A configuration write whose data differs from the stored word raises support_req_o for exactly the next cycle. A write of the same value raises nothing.
- R9: full_addr_o is high on every sync. It is also high on every traced retire while bit 0 of the stored configuration is 1.
- R10: Without a traced retire in the cycle, sync_req_o, full_addr_o and last_o are 0 and sync_reason_o is 0. This includes retires while trace_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Tracing enabled |
| iret_valid_i | input | 1 | An instruction retires this cycle |
| trap_i | input | 1 | Trap (interrupt or exception) taken this cycle |
| halt_i | input | 1 | Processor halts this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write data, bit 0 is full-address mode |
| sync_req_o | output | 1 | This retire must be sent as a full sync |
| sync_reason_o | output | 2 | Sync cause code: 0 reset, 1 start, 2 trap, 3 timeout |
| full_addr_o | output | 1 | Send this retire with a full address |
| support_req_o | output | 1 | Emit a configuration-report packet |
| last_o | output | 1 | This retire is the last before a trap or halt |

## Verification
The bench goes after overlapping causes. Reset and trace start can land on one retire, and so can a trap with a re-enable. A design with the priority reversed reports the wrong code there. It times the trap that comes in the same cycle as a retire: a design that fires the handler sync too early would mark that retire as the handler entry. It counts retires between timeouts after syncs of every reason, which exposes a counter that is not reloaded or that wraps. It also writes the configuration with unchanged values, where a careless change detector would request a report packet.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        RSN_RESET   = 2'd0,
        RSN_START   = 2'd1,
        RSN_TRAP    = 2'd2,
        RSN_TIMEOUT = 2'd3
    } rsn_e;

    typedef struct packed {
        logic rst_pend;
        logic start_pend;
        logic trap_pend;
        logic en_prev;
    } cond_st_t;

endpackage

// File: rtl/trs_cond.sv
module trs_cond
    import trs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       trace_en_i,
    input  logic       traced_i,
    input  logic       trap_i,
    input  logic       tmo_hit_i,
    output logic       sync_o,
    output rsn_e       reason_o
);

    cond_st_t st_d, st_q;
    logic     rise;
    logic     start_now;
    logic     any_cause;

    always_comb begin
        st_d      = st_q;
        rise      = trace_en_i & ~st_q.en_prev;
        start_now = st_q.start_pend | rise;
        any_cause = st_q.rst_pend | start_now | st_q.trap_pend | tmo_hit_i;
        sync_o    = traced_i & any_cause;

        reason_o = RSN_RESET;
        if (sync_o) begin
            if (st_q.rst_pend)       reason_o = RSN_RESET;
            else if (start_now)      reason_o = RSN_START;
            else if (st_q.trap_pend) reason_o = RSN_TRAP;
            else                     reason_o = RSN_TIMEOUT;
        end

        st_d.rst_pend   = st_q.rst_pend & ~traced_i;
        st_d.start_pend = trace_en_i & start_now & ~traced_i;
        st_d.trap_pend  = (st_q.trap_pend & ~traced_i) | trap_i;
        st_d.en_prev    = trace_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.rst_pend   <= 1'b1;
            st_q.start_pend <= 1'b0;
            st_q.trap_pend  <= 1'b0;
            st_q.en_prev    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/trs_timeout.sv
module trs_timeout #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             traced_i,
    input  logic             sync_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CntTop = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        hit_o = (cnt_q == CntTop);
        if (traced_i) begin
            if (sync_i) cnt_d = '0;
            else        cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/trs_cfg.sv
module trs_cfg #(
    parameter int unsigned CFG_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             support_o
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
        logic             sup;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sup = 1'b0;
        if (we_i) begin
            st_d.sup  = (wdata_i != st_q.word);
            st_d.word = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o     = st_q.word;
    assign support_o = st_q.sup;

endmodule

// File: rtl/trace_resync_unit.sv
module trace_resync_unit
    import trs_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned CFG_W    = 4,
    parameter int unsigned FULL_BIT = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trace_en_i,
    input  logic             iret_valid_i,
    input  logic             trap_i,
    input  logic             halt_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             sync_req_o,
    output logic [1:0]       sync_reason_o,
    output logic             full_addr_o,
    output logic             support_req_o,
    output logic             last_o
);

    logic             traced;
    logic             sync;
    rsn_e             reason;
    logic             tmo_hit;
    logic [CNT_W-1:0] tmo_cnt;
    logic [CFG_W-1:0] cfg_word;

    assign traced = iret_valid_i & trace_en_i;

    trs_cond u_cond (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trace_en_i (trace_en_i),
        .traced_i   (traced),
        .trap_i     (trap_i),
        .tmo_hit_i  (tmo_hit),
        .sync_o     (sync),
        .reason_o   (reason)
    );

    trs_timeout #(.CNT_W(CNT_W)) u_tmo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .traced_i (traced),
        .sync_i   (sync),
        .hit_o    (tmo_hit),
        .cnt_o    (tmo_cnt)
    );

    trs_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wdata_i),
        .cfg_o     (cfg_word),
        .support_o (support_req_o)
    );

    always_comb begin
        sync_req_o    = sync;
        sync_reason_o = reason;
        full_addr_o   = traced & (sync | cfg_word[FULL_BIT]);
        last_o        = traced & (trap_i | halt_i);
    end

endmodule

// File: rtl/trace_resync_chk.sv
module trace_resync_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trace_en_i,
    input logic             iret_valid_i,
    input logic             trap_i,
    input logic             halt_i,
    input logic             cfg_we_i,
    input logic             sync_req_o,
    input logic [1:0]       sync_reason_o,
    input logic             full_addr_o,
    input logic             support_req_o,
    input logic             last_o,
    input logic [CNT_W-1:0] tmo_cnt
);

    logic traced;
    logic seen_q;
    assign traced = iret_valid_i & trace_en_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     seen_q <= 1'b0;
        else if (traced) seen_q <= 1'b1;
    end

    p_first_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && !seen_q |-> sync_req_o && sync_reason_o == 2'd0);

    p_start_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && !$past(trace_en_i) |-> sync_req_o && sync_reason_o <= 2'd1);

    p_handler_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && $past(trap_i) |-> sync_req_o && sync_reason_o != 2'd3);

    p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && tmo_cnt == {CNT_W{1'b1}} |-> sync_req_o);

    p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && sync_req_o |=> tmo_cnt == '0);

    p_last_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        traced && (trap_i || halt_i) |-> last_o);

    p_support_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        support_req_o |-> $past(cfg_we_i));

    p_sync_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_req_o |-> full_addr_o);

    p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !traced |-> !sync_req_o && !full_addr_o && !last_o && sync_reason_o == 2'd0);

endmodule

bind trace_resync_unit trace_resync_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trace_en_i    (trace_en_i),
    .iret_valid_i  (iret_valid_i),
    .trap_i        (trap_i),
    .halt_i        (halt_i),
    .cfg_we_i      (cfg_we_i),
    .sync_req_o    (sync_req_o),
    .sync_reason_o (sync_reason_o),
    .full_addr_o   (full_addr_o),
    .support_req_o (support_req_o),
    .last_o        (last_o),
    .tmo_cnt       (tmo_cnt)
);

// File: tb/trace_resync_unit_tb_top.sv
module trace_resync_unit_tb_top;

    localparam int CNT_W = 4;
    localparam int CFG_W = 4;
    localparam int TOP   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0, v = 1'b0, trap = 1'b0, halt = 1'b0, we = 1'b0;
    logic [CFG_W-1:0] wd = '0;
    logic             sync_o, full_o, sup_o, last_o;
    logic [1:0]       rsn_o;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    bit m_rst, m_start, m_trap, m_enp, m_sup;
    int m_cnt, m_cfg;
    int syncs_seen[4];

    always #5 clk = ~clk;

    trace_resync_unit #(.CNT_W(CNT_W), .CFG_W(CFG_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .trace_en_i(en), .iret_valid_i(v),
        .trap_i(trap), .halt_i(halt), .cfg_we_i(we), .cfg_wdata_i(wd),
        .sync_req_o(sync_o), .sync_reason_o(rsn_o), .full_addr_o(full_o),
        .support_req_o(sup_o), .last_o(last_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_rst = 1; m_start = 0; m_trap = 0; m_enp = 0; m_sup = 0;
            m_cnt = 0; m_cfg = 0;
        end else begin
            bit    traced, start_now, tmo, e_sync, e_full, e_last, nsup;
            int    e_rsn, nflags;
            string tag;
            traced    = v && en;
            start_now = m_start || (en && !m_enp);
            tmo       = (m_cnt == TOP);
            e_sync    = traced && (m_rst || start_now || m_trap || tmo);
            e_rsn     = !e_sync ? 0 : m_rst ? 0 : start_now ? 1 : m_trap ? 2 : 3;
            e_full    = traced && (e_sync || m_cfg[0]);
            e_last    = traced && (trap || halt);
            nflags    = int'(m_rst) + int'(start_now) + int'(m_trap) + int'(tmo);
            if (!traced)             tag = "R10";
            else if (!e_sync)        tag = "R4 R5";
            else if (e_rsn == 0)     tag = "R1";
            else if (e_rsn == 1)     tag = "R2";
            else if (e_rsn == 2)     tag = "R3";
            else                     tag = "R4 R5";
            if (e_sync && nflags > 1) tag = {tag, " R6"};
            chk(sync_o == e_sync, {tag, " sync"}, sync_o, e_sync);
            chk(rsn_o == 2'(e_rsn), {tag, " reason"}, rsn_o, e_rsn);
            chk(full_o == e_full, "R9 full address", full_o, e_full);
            chk(last_o == e_last, "R7 last flag", last_o, e_last);
            chk(sup_o == m_sup, "R8 support request", sup_o, m_sup);
            if (e_sync) syncs_seen[e_rsn]++;
            // advance the model
            m_rst   = m_rst && !traced;
            m_start = en && start_now && !traced;
            m_trap  = (m_trap && !traced) || trap;
            m_enp   = en;
            if (traced) m_cnt = e_sync ? 0 : m_cnt + 1;
            nsup = 0;
            if (we) begin
                nsup  = (int'(wd) != m_cfg);
                m_cfg = int'(wd);
            end
            m_sup = nsup;
        end
    end

    task automatic cyc(input bit iv, input bit ien, input bit itr, input bit ih,
                       input bit iwe, input int iwd);
        @(posedge clk);
        #1;
        v = iv; en = ien; trap = itr; halt = ih; we = iwe; wd = CFG_W'(iwd);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: reset state, then retires with tracing off stay silent
        cyc(0, 0, 0, 0, 0, 0);
        chk(sync_o == 0 && full_o == 0 && last_o == 0 && sup_o == 0, "R10 reset state", sync_o, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
        // R1 with R6: enable and retire together, reset outranks start
        cyc(1, 1, 0, 0, 0, 0);
        // R4 R5: long straight run hits timeouts
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, 0, 0);
        // R3 R7: trap arrives with a retire, handler follows after a gap
        cyc(1, 1, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, 0);
        // R7: halt flags the retire
        cyc(1, 1, 0, 1, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        // R2: restart tracing with a gap before the first retire
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        // R6: trap pending while tracing restarts, start wins
        cyc(0, 0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        // R8 R9: configuration writes, including an unchanged value
        cyc(0, 1, 0, 0, 1, 1);
        cyc(1, 1, 0, 0, 1, 1);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 1, 4'b0101);
        cyc(1, 1, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            bit ren;
            ren = ($urandom % 60) != 0;
            cyc(($urandom % 4) != 0, ren, ($urandom % 20) == 0, ($urandom % 30) == 0,
                ($urandom % 25) == 0, ($urandom % 3 == 0) ? m_cfg : int'($urandom % 16));
        end
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        for (int r = 0; r < 4; r++)
            chk(syncs_seen[r] > 0, "R6 every reason code reached", syncs_seen[r], 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule